// File: doc/BRIEF.md
# I2S Reclocking Buffer

This block sits between a stereo serial audio source and a DAC. Samples arrive in the usual I2S framing, timed by the source's bit clock and word select. They are collected into left/right frames and written into a dual-clock buffer. A separate, clean master clock drains the buffer and serialises the frames again. The timing of the new output stream comes only from that master clock, so jitter on the incoming bit clock never reaches the DAC. The output bit clock is the master clock divided by four. Every output pin is driven from a flip-flop clocked by the master clock.

The two clocks are unrelated, and nothing is fed back to the source. The read side therefore keeps the buffer's occupancy under control on its own. At start-up it plays silence until the buffer is half full. During a stream it discards a whole frame when the buffer is nearly full and repeats the previous frame when it has run dry. When the input goes quiet, it plays out frames only down to the half-full mark and then holds there, so the next stream starts with margin on both sides. The read side also reports the buffer's fill level and two sticky flags, one for discarded frames and one for inserted frames.

Top module: `i2s_reclock_fifo`

## Requirements
- R1: While reset is asserted and just after it is released, out_bclk, out_ws and out_sd are low, fill_level is 0, and both flags are 0.
- R2: out_bclk is mclk divided by 4, high for 2 mclk cycles and low for 2. out_ws and out_sd change only in the mclk cycle in which out_bclk falls.
- R3: Output framing has SAMPLE_W-bit slots, sent MSB first. out_ws low marks the left slot and high marks the right slot. out_ws changes one bit period before the MSB of each slot, so it toggles every SAMPLE_W bit periods.
- R4: The input is sampled on rising in_bclk with the same framing as the output. A frame is stored when in_ws goes from high to low, which completes the right word. A right word with no left word captured before it is discarded.
- R5: Until a frame is first read from the buffer, out_sd stays at 0. The first read happens when the fill level reaches DEPTH/2, and the first frame played is the oldest frame stored.
- R6: When the two frame rates match exactly, every stored frame is played once, in order, with no silence once playback has started.
- R7: At a frame boundary during playback, a fill level of DEPTH-1 or more makes the read side play one frame and skip the next whole frame. This sets overrun_flag.
- R8: At a frame boundary during playback, a fill level of 0 makes the read side repeat the previous frame in full. This sets underrun_flag.
- R9: Left and right words are never exchanged. Frames are played in non-decreasing order of arrival.
- R10: A gap is declared when no in_ws edge arrives for GAP_CYCLES mclk cycles. During a gap, frames are played while the fill level is above DEPTH/2, then silence is sent, leaving the fill level at exactly DEPTH/2. Playback resumes after the gap only once the fill level is at least DEPTH/2.
- R11: Both flags stay set until status_clr is high at an mclk edge. fill_level never exceeds DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Clean output master clock |
| rst_n | input | 1 | Asynchronous active-low reset for both sides |
| in_bclk | input | 1 | Incoming bit clock |
| in_ws | input | 1 | Incoming word select (low = left) |
| in_sd | input | 1 | Incoming serial data |
| status_clr | input | 1 | Clears both sticky flags (mclk domain) |
| out_mclk | output | 1 | Master clock forwarded to the DAC |
| out_bclk | output | 1 | Output bit clock, mclk/4, registered |
| out_ws | output | 1 | Output word select, registered |
| out_sd | output | 1 | Output serial data, registered |
| fill_level | output | ADDR_W+1 | Frames held, as seen by the read side |
| underrun_flag | output | 1 | Sticky: a frame was repeated |
| overrun_flag | output | 1 | Sticky: a frame was discarded |

## Verification
Some properties are checked by assertions on every master clock cycle. Serial outputs change only on a falling output bit clock. Data stays silent before the first read. A flag rises only when the fill level at the preceding boundary justified it. The flags stay set until cleared, and the fill level stays within its bound. Other behaviour can only be shown by the bench's scenarios, by decoding the output stream against the frames sent: the exact start-up point, gap-free playback at matched rates, skipped frames under a fast source, repeated frames under a slow one, and recentering to exactly half full during a gap.

// File: rtl/i2s_reclock_fifo.sv
module i2s_reclock_fifo #(
  parameter int SAMPLE_W   = 16,
  parameter int ADDR_W     = 4,
  parameter int GAP_CYCLES = 512
) (
  input  logic              mclk,
  input  logic              rst_n,
  input  logic              in_bclk,
  input  logic              in_ws,
  input  logic              in_sd,
  input  logic              status_clr,
  output logic              out_mclk,
  output logic              out_bclk,
  output logic              out_ws,
  output logic              out_sd,
  output logic [ADDR_W:0]   fill_level,
  output logic              underrun_flag,
  output logic              overrun_flag
);
  localparam int FW    = 2 * SAMPLE_W;
  localparam int DEPTH = 1 << ADDR_W;
  localparam int HALF  = DEPTH / 2;
  localparam int PW    = ADDR_W + 1;
  localparam int BCW   = $clog2(FW);
  localparam int GW    = $clog2(GAP_CYCLES + 1);

  function automatic logic [PW-1:0] b2g(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [FW-1:0] mem [DEPTH];

  // ---------------- write side (in_bclk) ----------------
  logic                ws_d, have_left;
  logic [SAMPLE_W-2:0] sreg;
  logic [SAMPLE_W-1:0] left_q, word;
  logic [PW-1:0]       wbin, wgray, rsync1, rsync2;
  logic                wfull, wr_en;

  assign word  = {sreg, in_sd};
  assign wfull = (wgray == {~rsync2[PW-1:PW-2], rsync2[PW-3:0]});
  assign wr_en = (in_ws != ws_d) && ws_d && have_left && !wfull;

  always_ff @(posedge in_bclk or negedge rst_n) begin
    if (!rst_n) begin
      ws_d <= 1'b1; have_left <= 1'b0; sreg <= '0; left_q <= '0;
      wbin <= '0; wgray <= '0; rsync1 <= '0; rsync2 <= '0;
    end else begin
      rsync1 <= rgray; rsync2 <= rsync1;
      ws_d <= in_ws;
      sreg <= word[SAMPLE_W-2:0];
      if (in_ws != ws_d) begin
        if (!ws_d) begin
          left_q <= word; have_left <= 1'b1;
        end else begin
          have_left <= 1'b0;
        end
      end
      if (wr_en) begin
        wbin  <= wbin + 1'b1;
        wgray <= b2g(wbin + 1'b1);
      end
    end
  end

  always_ff @(posedge in_bclk)
    if (wr_en) mem[wbin[ADDR_W-1:0]] <= {left_q, word};

  // ---------------- read side (mclk) ----------------
  logic [PW-1:0]  rbin, rgray, wsync1, wsync2, level;
  logic [1:0]     div_q, step;
  logic [BCW-1:0] bitcnt;
  logic [FW-1:0]  shreg, last_q, mem_q, load_val;
  logic           run_q, run_nx, primed_q, from_mem, hit_ovr, hit_unr;
  logic           ws_s1, ws_s2, ws_s3, gap;
  logic [GW-1:0]  gcnt;
  logic           bit_edge, frame_edge, ws_int;

  assign out_mclk   = mclk;
  assign level      = g2b(wsync2) - rbin;
  assign fill_level = level;
  assign mem_q      = mem[rbin[ADDR_W-1:0]];
  assign gap        = (gcnt == GW'(GAP_CYCLES));
  assign bit_edge   = (div_q == 2'd3);
  assign frame_edge = bit_edge && (bitcnt == BCW'(FW - 1));
  assign ws_int     = (bitcnt >= BCW'(SAMPLE_W - 1)) && (bitcnt != BCW'(FW - 1));

  always_comb begin
    load_val = '0; step = 2'd0; from_mem = 1'b0;
    hit_ovr = 1'b0; hit_unr = 1'b0; run_nx = run_q;
    if (gap) begin
      run_nx = 1'b0;
      if (level > PW'(HALF)) begin
        load_val = mem_q; step = 2'd1; from_mem = 1'b1;
      end
    end else if (run_q || level >= PW'(HALF)) begin
      run_nx = 1'b1;
      if (level == '0) begin
        load_val = last_q; hit_unr = 1'b1;
      end else if (level >= PW'(DEPTH - 1)) begin
        load_val = mem_q; step = 2'd2; from_mem = 1'b1; hit_ovr = 1'b1;
      end else begin
        load_val = mem_q; step = 2'd1; from_mem = 1'b1;
      end
    end
  end

  always_ff @(posedge mclk or negedge rst_n) begin
    if (!rst_n) begin
      wsync1 <= '0; wsync2 <= '0; rbin <= '0; rgray <= '0;
      ws_s1 <= 1'b1; ws_s2 <= 1'b1; ws_s3 <= 1'b1; gcnt <= '0;
      div_q <= '0; bitcnt <= '0; shreg <= '0; last_q <= '0;
      run_q <= 1'b0; primed_q <= 1'b0;
      underrun_flag <= 1'b0; overrun_flag <= 1'b0;
      out_bclk <= 1'b0; out_ws <= 1'b0; out_sd <= 1'b0;
    end else begin
      wsync1 <= wgray; wsync2 <= wsync1;
      ws_s1 <= in_ws; ws_s2 <= ws_s1; ws_s3 <= ws_s2;
      if (ws_s2 != ws_s3) gcnt <= '0;
      else if (!gap)      gcnt <= gcnt + 1'b1;
      div_q <= div_q + 1'b1;
      if (bit_edge) begin
        bitcnt <= frame_edge ? '0 : bitcnt + 1'b1;
        shreg  <= frame_edge ? load_val : {shreg[FW-2:0], 1'b0};
      end
      if (status_clr) begin
        underrun_flag <= 1'b0; overrun_flag <= 1'b0;
      end
      if (frame_edge) begin
        run_q <= run_nx;
        rbin  <= rbin + PW'(step);
        rgray <= b2g(rbin + PW'(step));
        if (from_mem) begin
          last_q <= mem_q; primed_q <= 1'b1;
        end
        if (hit_ovr) overrun_flag  <= 1'b1;
        if (hit_unr) underrun_flag <= 1'b1;
      end
      out_bclk <= div_q[1];
      out_ws   <= ws_int;
      out_sd   <= shreg[FW-1];
    end
  end

  a_r2_sd_on_fall: assert property (@(posedge mclk) disable iff (!rst_n)
    !$stable(out_sd) |-> $fell(out_bclk));
  a_r2_ws_on_fall: assert property (@(posedge mclk) disable iff (!rst_n)
    !$stable(out_ws) |-> $fell(out_bclk));
  a_r5_silent_until_primed: assert property (@(posedge mclk) disable iff (!rst_n)
    !primed_q |=> !out_sd);
  a_r7_drop_needs_near_full: assert property (@(posedge mclk) disable iff (!rst_n)
    $rose(overrun_flag) |-> $past(fill_level) >= PW'(DEPTH - 1));
  a_r8_insert_needs_empty: assert property (@(posedge mclk) disable iff (!rst_n)
    $rose(underrun_flag) |-> $past(fill_level) == '0);
  a_r11_level_bound: assert property (@(posedge mclk) disable iff (!rst_n)
    fill_level <= PW'(DEPTH));
  a_r11_ovr_sticky: assert property (@(posedge mclk) disable iff (!rst_n)
    overrun_flag && !status_clr |=> overrun_flag);
  a_r11_unr_sticky: assert property (@(posedge mclk) disable iff (!rst_n)
    underrun_flag && !status_clr |=> underrun_flag);
endmodule

// File: tb/i2s_reclock_fifo_tb_top.sv
`timescale 1ns/1ps
module i2s_reclock_fifo_tb_top;
  localparam int W = 16;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;
  localparam int HALF = DEPTH / 2;

  logic mclk = 0, in_bclk = 0, rst_n = 0;
  logic in_ws = 1, in_sd = 0, status_clr = 0;
  logic out_mclk, out_bclk, out_ws, out_sd, underrun_flag, overrun_flag;
  logic [AW:0] fill_level;
  realtime half_ns = 20.0;

  i2s_reclock_fifo #(.SAMPLE_W(W), .ADDR_W(AW), .GAP_CYCLES(512)) dut_i (
    .mclk(mclk), .rst_n(rst_n), .in_bclk(in_bclk), .in_ws(in_ws), .in_sd(in_sd),
    .status_clr(status_clr), .out_mclk(out_mclk), .out_bclk(out_bclk), .out_ws(out_ws),
    .out_sd(out_sd), .fill_level(fill_level), .underrun_flag(underrun_flag),
    .overrun_flag(overrun_flag));

  always #5 mclk = ~mclk;
  always #(half_ns) in_bclk = ~in_bclk;

  int compared = 0, mismatched = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // stimulus state
  logic pend = 0;
  int sent = 0, next_id = 1;

  task automatic send_frame();
    logic [2*W-1:0] bits;
    bits = {next_id[W-1:0], next_id[W-1:0] ^ 16'h5A5A};
    for (int i = 0; i < 2 * W; i++) begin
      @(negedge in_bclk);
      in_ws <= (i >= W);
      in_sd <= pend;
      pend = bits[2*W-1-i];
    end
    next_id++; sent++;
  endtask

  // reference model: output decode and frame sequence
  bit pb = 0, pws = 0, psd = 0, seen_edge = 0, wsc_seen = 0, dws = 0;
  int run_len = 0, nbits = 0;
  logic [W-1:0] dsh = '0, dleft = '0;
  bit seen_nz = 0, strict = 1, last_zero = 0;
  int last_id = 0, repeats = 0, skips = 0;

  task automatic on_frame(input logic [W-1:0] l, input logic [W-1:0] r);
    if (l == 0 && r == 0) begin
      last_zero = 1;
      if (seen_nz && strict) chk(0, "R6 silence during matched playback", 0, 1);
      return;
    end
    last_zero = 0;
    chk(r == (l ^ 16'h5A5A), "R9 left/right pairing", r, l ^ 16'h5A5A);
    if (!seen_nz) begin
      chk(l == 1, "R4 R5 first played frame is oldest", l, 1);
      chk(sent >= HALF, "R5 playback starts at half full", sent, HALF);
      seen_nz = 1;
    end else begin
      chk(int'(l) >= last_id, "R9 frame order", l, last_id);
      if (strict) chk(int'(l) == last_id + 1, "R6 consecutive frames", l, last_id + 1);
      if (int'(l) == last_id) repeats++;
      if (int'(l) == last_id + 2) skips++;
    end
    last_id = int'(l);
  endtask

  always @(negedge mclk) begin
    if (rst_n && !done) begin
      chk(fill_level <= DEPTH, "R11 fill bound", fill_level, DEPTH);
      if (out_bclk != pb) begin
        if (seen_edge) chk(run_len == 2, "R2 bclk half period", run_len, 2);
        seen_edge = 1; run_len = 1;
        if (out_bclk) begin
          if (out_ws != dws) begin
            if (wsc_seen) chk(nbits == W, "R3 ws toggle spacing", nbits, W);
            wsc_seen = 1; nbits = 0;
            if (!dws) dleft = {dsh[W-2:0], out_sd};
            else on_frame(dleft, {dsh[W-2:0], out_sd});
          end
          nbits++;
          dsh = {dsh[W-2:0], out_sd};
          dws = out_ws;
        end
      end else run_len++;
      if (out_ws != pws || out_sd != psd)
        chk(pb && !out_bclk, "R2 data change on falling bclk", out_bclk, 0);
      pb = out_bclk; pws = out_ws; psd = out_sd;
    end
  end

  initial begin
    repeat (150000) @(posedge mclk);
    if (!done) begin
      done = 1;
      mismatched++; compared++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge mclk);
    chk(!out_bclk && !out_ws && !out_sd, "R1 serial outputs in reset",
        {out_bclk, out_ws, out_sd}, 0);
    chk(fill_level == 0, "R1 fill in reset", fill_level, 0);
    chk(!underrun_flag && !overrun_flag, "R1 flags in reset",
        {underrun_flag, overrun_flag}, 0);
    rst_n = 1;
    @(negedge mclk);
    chk(!out_bclk && !out_sd && fill_level == 0, "R1 state after release",
        {out_bclk, out_sd}, 0);

    // matched rate
    repeat (60) send_frame();
    chk(seen_nz, "R5 playback started", seen_nz, 1);
    chk(!underrun_flag && !overrun_flag, "R6 no slip at matched rate",
        {underrun_flag, overrun_flag}, 0);
    chk(fill_level >= HALF - 2 && fill_level <= HALF + 2, "R6 level near half",
        fill_level, HALF);

    // fast source
    strict = 0;
    half_ns = 18.0;
    repeat (150) send_frame();
    chk(overrun_flag, "R7 overrun flag", overrun_flag, 1);
    chk(skips > 0, "R7 frames skipped", skips, 1);
    chk(!underrun_flag, "R8 no insert with fast source", underrun_flag, 0);

    // gap
    half_ns = 20.0;
    @(negedge in_bclk); in_ws <= 0; in_sd <= pend; pend = 0;
    repeat (40 * 2 * W) @(negedge in_bclk);
    @(negedge mclk);
    chk(fill_level == HALF, "R10 recentred to half", fill_level, HALF);
    chk(last_zero, "R10 silence after draining", last_zero, 1);
    chk(overrun_flag, "R11 overrun sticky", overrun_flag, 1);
    status_clr = 1;
    @(negedge mclk);
    status_clr = 0;
    @(negedge mclk);
    chk(!overrun_flag && !underrun_flag, "R11 cleared by status_clr",
        {underrun_flag, overrun_flag}, 0);

    // slow source
    half_ns = 23.0;
    repeat (150) send_frame();
    chk(underrun_flag, "R8 underrun flag", underrun_flag, 1);
    chk(repeats > 0, "R8 frames repeated", repeats, 1);
    chk(!overrun_flag, "R7 no drop with slow source", overrun_flag, 0);
    chk(!last_zero, "R10 playback resumed after gap", last_zero, 0);

    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule